// File: doc/BRIEF.md
# Single-Byte Serial Port with Register Access

The block is a serial port that a processor drives through a small 32-bit register bus. It turns a written byte into one asynchronous serial character on its output line. It also turns one arriving character into a byte held in a one-entry receive register. A status word reports whether a byte is waiting, whether the transmitter is busy, and whether a byte was lost or arrived damaged. Three single-cycle pulse outputs signal a received byte, a started transmission and an error.

The bus has two windows, chosen by `bus_win`. Window 0 holds the receive data word, the transmit data word and the status word. Window 1 holds the divisor that sets the line rate. Each character has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Every bit lasts 16 ticks of an oversampling clock, and that tick comes once every divisor+1 system clocks. Parameters remove the receive path or the transmit path, turn parity on (even or odd), and gate each pulse output.

Top module: `byte_uart`

## Requirements
- R1: The status word (window 0, offset 0x8) has bit 0 = byte waiting, bit 3 = transmitter busy, bit 5 = overrun, bit 6 = framing error and bit 7 = parity error, and every other bit reads as zero. After reset every register, the status word and all three pulse outputs are zero, and the serial output is high.
- R2: When a character finishes arriving while no byte is waiting, its byte goes into bits [7:0] of the receive data word (window 0, offset 0x0) and the byte-waiting bit is set. `irq_rx` then pulses high for exactly one cycle.
- R3: When a character finishes arriving while a byte is already waiting, the new byte is dropped, the held byte stays unchanged, the overrun bit is set and `irq_err` pulses for one cycle.
- R4: Reading the receive data word returns the held byte in bits [7:0] and clears the byte-waiting, overrun, framing-error and parity-error bits.
- R5: Reading the status word returns its current value and then clears the overrun bit only. The other status bits are unchanged.
- R6: Writing window 0, offset 0x4 while the transmitter is idle sends bits [7:0] of the write data as one character. The character is: start bit 0, the eight data bits LSB first, the parity bit (XOR of the data bits, so even parity) and stop bit 1. Each bit lasts 16*(divisor+1) clocks, and the line is high when idle.
- R7: The busy bit is set on the clock edge that accepts the transmit write and clears at the end of the stop bit. A transmit write made while busy is ignored. `irq_tx` pulses for one cycle on each accepted write.
- R8: A character whose stop bit is sampled low is stored with the framing-error bit set, and `irq_err` pulses.
- R9: A character whose parity bit does not match its data is stored with the parity-error bit set, and `irq_err` pulses.
- R10: The divisor is read and written at window 1, offset 0x0 in bits [DIV_W-1:0]. Upper write bits are dropped, and the divisor resets to 0, which gives one oversampling tick every clock.
- R11: An instance built with the receive path, the transmit path and all pulse enables off ignores arriving characters and transmit writes. Its status word reads zero, its line stays high and its pulse outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_win | input | 1 | Register window: 0 data/status, 1 divisor |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| serial_in | input | 1 | Serial receive line |
| serial_out | output | 1 | Serial transmit line |
| irq_err | output | 1 | One-cycle pulse on overrun, framing or parity error |
| irq_tx | output | 1 | One-cycle pulse on an accepted transmit write |
| irq_rx | output | 1 | One-cycle pulse on an accepted received byte |

## Verification
The receiver gets all 256 byte values with correct framing, and the transmitter sends all 256 values. Together these separate bit-order, parity and data-path faults that a few chosen bytes would miss. Characters with a low stop bit, with a flipped parity bit, and sent back to back without a read each produce a distinct status pattern. These patterns tell the framing, parity and overrun paths apart from normal reception and from each other. Running at a nonzero divisor shows that bit length follows the divisor. A second instance with every path disabled, fed the same stimulus, shows that the enables really gate behaviour.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OVS      = 16;
    localparam int unsigned FRAME_MX = 11;

    localparam logic [3:0] OFF_RXD  = 4'h0;
    localparam logic [3:0] OFF_TXD  = 4'h4;
    localparam logic [3:0] OFF_STAT = 4'h8;
    localparam logic [3:0] OFF_DIV  = 4'h0;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
        logic       par_err;
    } rx_result_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_BITS, RX_PAR, RX_STOP, RX_BREAK
    } rx_state_t;

    function automatic logic parity_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input logic valid, input logic busy, input logic ovr,
        input logic ferr, input logic perr);
        logic [WORD_W-1:0] s;
        s    = '0;
        s[0] = valid;
        s[3] = busy;
        s[5] = ovr;
        s[6] = ferr;
        s[7] = perr;
        return s;
    endfunction

endpackage

// File: rtl/byte_uart_baud.sv
module byte_uart_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R10: a nonzero steady divisor spaces ticks at least two clocks apart
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && divisor != '0 && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/byte_uart_tx.sv
module byte_uart_tx
    import byte_uart_pkg::*;
#(
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       line,
    output logic       busy
);
    localparam int unsigned FRAME_BITS = 10 + (PARITY_EN ? 1 : 0);

    logic [FRAME_MX-1:0] shreg;
    logic [3:0]          remaining;
    logic [3:0]          sub;
    logic                extra;

    assign extra = PARITY_EN ? parity_of(data, PARITY_ODD) : 1'b1;
    assign line  = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '1;
            remaining <= '0;
            sub       <= '0;
            busy      <= 1'b0;
        end else if (start && !busy) begin
            shreg     <= {1'b1, extra, data, 1'b0};
            remaining <= 4'(FRAME_BITS - 1);
            sub       <= '0;
            busy      <= 1'b1;
        end else if (busy && tick) begin
            if (sub == 4'(OVS - 1)) begin
                sub <= '0;
                if (remaining == '0) begin
                    busy <= 1'b0;
                end else begin
                    shreg     <= {1'b1, shreg[FRAME_MX-1:1]};
                    remaining <= remaining - 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // R7: busy can only drop on an oversampling tick
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx
    import byte_uart_pkg::*;
#(
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line_in,
    output logic       done,
    output rx_result_t res
);
    logic [1:0] sync;
    logic       rxs;
    rx_state_t  state;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_s;

    assign rxs = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            par_s <= 1'b0;
            done  <= 1'b0;
            res   <= '0;
        end else begin
            sync <= {sync[0], line_in};
            done <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    sub <= '0;
                    if (!rxs) state <= RX_START;
                end
                RX_START: if (tick) begin
                    if (sub == 4'(OVS / 2 - 1)) begin
                        sub   <= '0;
                        bitn  <= '0;
                        state <= rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (sub == 4'(OVS - 1)) begin
                        sub   <= '0;
                        shreg <= {rxs, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= PARITY_EN ? RX_PAR : RX_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                RX_PAR: if (tick) begin
                    if (sub == 4'(OVS - 1)) begin
                        sub   <= '0;
                        par_s <= rxs;
                        state <= RX_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (sub == 4'(OVS - 1)) begin
                        sub           <= '0;
                        done          <= 1'b1;
                        res.data      <= shreg;
                        res.frame_err <= !rxs;
                        res.par_err   <= PARITY_EN &&
                                         (parity_of(shreg, PARITY_ODD) != par_s);
                        state         <= rxs ? RX_IDLE : RX_BREAK;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                RX_BREAK: if (rxs) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R2: one completed character gives a single-cycle completion strobe
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/byte_uart.sv
module byte_uart
    import byte_uart_pkg::*;
#(
    parameter bit          RX_EN       = 1'b1,
    parameter bit          TX_EN       = 1'b1,
    parameter bit          RX_IRQ_EN   = 1'b1,
    parameter bit          TX_IRQ_EN   = 1'b1,
    parameter bit          ERR_IRQ_EN  = 1'b1,
    parameter bit          PARITY_EN   = 1'b1,
    parameter bit          PARITY_ODD  = 1'b0,
    parameter int unsigned DIV_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_win,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        serial_in,
    output logic        serial_out,
    output logic        irq_err,
    output logic        irq_tx,
    output logic        irq_rx
);
    logic [DIV_W-1:0] divisor;
    logic             tick;
    logic             rx_valid, ovr, ferr, perr;
    logic [7:0]       rx_data;
    logic             rx_done;
    rx_result_t       rx_res;
    logic             tx_busy, tx_start;
    logic             rd_data, rd_stat, wr_tx, wr_div, rd_div;
    logic             valid_eff;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[31:DIV_W];

    assign rd_data  = bus_req && !bus_we && !bus_win && bus_addr == OFF_RXD;
    assign rd_stat  = bus_req && !bus_we && !bus_win && bus_addr == OFF_STAT;
    assign rd_div   = bus_req && !bus_we &&  bus_win && bus_addr == OFF_DIV;
    assign wr_tx    = bus_req &&  bus_we && !bus_win && bus_addr == OFF_TXD;
    assign wr_div   = bus_req &&  bus_we &&  bus_win && bus_addr == OFF_DIV;
    assign tx_start = TX_EN && wr_tx && !tx_busy;
    assign valid_eff = rx_valid && !rd_data;

    always_comb begin
        bus_rdata = '0;
        if (rd_div)  bus_rdata = WORD_W'(divisor);
        if (rd_data) bus_rdata = WORD_W'(rx_data);
        if (rd_stat) bus_rdata = pack_status(rx_valid, tx_busy, ovr, ferr, perr);
    end

    byte_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    generate
        if (RX_EN) begin : g_rx
            byte_uart_rx #(.PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
                .clk(clk), .rst(rst), .tick(tick), .line_in(serial_in),
                .done(rx_done), .res(rx_res)
            );
        end else begin : g_no_rx
            logic unused_rx_line;
            assign unused_rx_line = serial_in;
            assign rx_done = 1'b0;
            assign rx_res  = '0;
        end

        if (TX_EN) begin : g_tx
            byte_uart_tx #(.PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
                .clk(clk), .rst(rst), .tick(tick), .start(tx_start),
                .data(bus_wdata[7:0]), .line(serial_out), .busy(tx_busy)
            );
        end else begin : g_no_tx
            assign serial_out = 1'b1;
            assign tx_busy    = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor  <= '0;
            rx_valid <= 1'b0;
            ovr      <= 1'b0;
            ferr     <= 1'b0;
            perr     <= 1'b0;
            rx_data  <= '0;
            irq_err  <= 1'b0;
            irq_tx   <= 1'b0;
            irq_rx   <= 1'b0;
        end else begin
            irq_err <= 1'b0;
            irq_rx  <= 1'b0;
            irq_tx  <= TX_IRQ_EN && tx_start;
            if (wr_div) divisor <= bus_wdata[DIV_W-1:0];
            if (rd_data) begin
                rx_valid <= 1'b0;
                ovr      <= 1'b0;
                ferr     <= 1'b0;
                perr     <= 1'b0;
            end
            if (rd_stat) ovr <= 1'b0;
            if (rx_done) begin
                if (valid_eff) begin
                    ovr     <= 1'b1;
                    irq_err <= ERR_IRQ_EN;
                end else begin
                    rx_data  <= rx_res.data;
                    rx_valid <= 1'b1;
                    ferr     <= rx_res.frame_err;
                    perr     <= rx_res.par_err;
                    irq_rx   <= RX_IRQ_EN;
                    irq_err  <= ERR_IRQ_EN && (rx_res.frame_err || rx_res.par_err);
                end
            end
        end
    end

    // R2: receive pulse lasts one cycle
    p_rx_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        irq_rx |=> !irq_rx);

    // R3: a dropped byte leaves the held data untouched and flags overrun
    p_ovr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_valid && !rd_data) |=> (ovr && rx_data == $past(rx_data)));

    // R4: a data read with no arrival in the same cycle clears all flags
    p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_done) |=> (!rx_valid && !ovr && !ferr && !perr));

    // R5: a status read clears overrun but keeps byte-waiting
    p_stat_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rx_done) |=> (!ovr && rx_valid == $past(rx_valid)));

    // R7: a transmit write made while busy raises no transmit pulse
    p_tx_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && tx_busy) |=> !irq_tx);

endmodule

// File: tb/byte_uart_test.sv
module byte_uart_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_win = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        serial_in = 1'b1;
    logic [31:0] rdata, off_rdata;
    logic        serial_out, irq_err, irq_tx, irq_rx;
    logic        off_out, off_err, off_tx, off_rx;

    int n_chk = 0, n_err = 0;
    int c_rx = 0, c_tx = 0, c_err = 0, c_off = 0, c_off_low = 0;
    int run_rx = 0, run_tx = 0, run_err = 0, c_long = 0;
    int div_cur = 0;
    bit finished = 0;

    always #(CLK_P / 2) clk = ~clk;

    byte_uart uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .serial_in(serial_in), .serial_out(serial_out),
        .irq_err(irq_err), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    byte_uart #(.RX_EN(1'b0), .TX_EN(1'b0), .RX_IRQ_EN(1'b0), .TX_IRQ_EN(1'b0),
                .ERR_IRQ_EN(1'b0)) uut_off (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(off_rdata),
        .serial_in(serial_in), .serial_out(off_out),
        .irq_err(off_err), .irq_tx(off_tx), .irq_rx(off_rx)
    );

    always @(negedge clk) if (!rst) begin
        if (irq_rx)  c_rx++;
        if (irq_tx)  c_tx++;
        if (irq_err) c_err++;
        if (off_rx || off_tx || off_err) c_off++;
        if (!off_out) c_off_low++;
        run_rx  = irq_rx  ? run_rx + 1  : 0;
        run_tx  = irq_tx  ? run_tx + 1  : 0;
        run_err = irq_err ? run_err + 1 : 0;
        if (run_rx > 1 || run_tx > 1 || run_err > 1) c_long++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic win, input logic [3:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_win = win; bus_addr = a;
        #1 d = rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic wr(input logic win, input logic [3:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input logic stop_lvl);
        int bc;
        bc = 16 * (div_cur + 1);
        serial_in = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i];
            repeat (bc) @(negedge clk);
        end
        serial_in = (^b) ^ bad_par;
        repeat (bc) @(negedge clk);
        serial_in = stop_lvl;
        repeat (bc) @(negedge clk);
        serial_in = 1'b1;
        repeat (stop_lvl ? 4 : bc) @(negedge clk);
    endtask

    function automatic logic tx_bit(input logic [7:0] b, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i-1];
        if (i == 9) return ^b;
        return 1'b1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int base_rx, base_tx, base_err;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R10: reset state
        rd(0, 4'h8, d); chk("R1 status reset", d, 32'h0);
        rd(0, 4'h0, d); chk("R1 data reset", d, 32'h0);
        rd(1, 4'h0, d); chk("R10 divisor reset", d, 32'h0);
        chk("R1 line idle", {31'b0, serial_out}, 32'h1);
        chk("R1 irqs reset", {29'b0, irq_err, irq_tx, irq_rx}, 32'h0);

        // R2 / R4: every byte value received
        for (int b = 0; b < 256; b++) begin
            base_rx = c_rx;
            send_frame(8'(b), 1'b0, 1'b1);
            rd(0, 4'h8, d); chk("R2 status valid", d, 32'h1);
            chk("R2 rx pulse", c_rx - base_rx, 1);
            rd(0, 4'h0, d); chk("R2 data", d, 32'(b));
            rd(0, 4'h8, d); chk("R4 flags cleared", d, 32'h0);
        end

        // R6 / R7: every byte value transmitted
        for (int b = 0; b < 256; b++) begin
            base_tx = c_tx;
            wr(0, 4'h4, 32'hABCD_0000 | 32'(b));
            rd(0, 4'h8, d); chk("R7 busy after write", d, 32'h8);
            repeat (7) @(negedge clk);
            for (int i = 0; i < 11; i++) begin
                if (i > 0) repeat (16) @(negedge clk);
                chk("R6 line bit", {31'b0, serial_out}, {31'b0, tx_bit(8'(b), i)});
            end
            rd(0, 4'h8, d); chk("R7 busy in stop", d, 32'h8);
            repeat (6) @(negedge clk);
            rd(0, 4'h8, d); chk("R7 busy last cycle", d, 32'h8);
            rd(0, 4'h8, d); chk("R7 busy cleared", d, 32'h0);
            chk("R7 tx pulse", c_tx - base_tx, 1);
        end

        // R7: write while busy is ignored
        base_tx = c_tx;
        wr(0, 4'h4, 32'h11);
        wr(0, 4'h4, 32'h55);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            if (i > 0) repeat (16) @(negedge clk);
            chk("R7 first frame kept", {31'b0, serial_out}, {31'b0, tx_bit(8'h11, i)});
        end
        begin
            int lows;
            lows = 0;
            repeat (250) begin
                @(negedge clk);
                if (!serial_out) lows++;
            end
            chk("R7 second write dropped", lows, 0);
        end
        chk("R7 one tx pulse", c_tx - base_tx, 1);

        // R3 / R4: overrun
        base_err = c_err;
        send_frame(8'h3C, 1'b0, 1'b1);
        send_frame(8'hC3, 1'b0, 1'b1);
        chk("R3 err pulse", c_err - base_err, 1);
        rd(0, 4'h0, d); chk("R3 held data kept", d, 32'h3C);
        rd(0, 4'h8, d); chk("R4 overrun cleared by data read", d, 32'h0);

        // R5: status read clears overrun only
        send_frame(8'h3C, 1'b0, 1'b1);
        send_frame(8'hC3, 1'b0, 1'b1);
        rd(0, 4'h8, d); chk("R5 status shows overrun", d, 32'h21);
        rd(0, 4'h8, d); chk("R5 overrun cleared", d, 32'h1);
        rd(0, 4'h0, d); chk("R5 data kept", d, 32'h3C);

        // R8: framing error
        base_err = c_err; base_rx = c_rx;
        send_frame(8'h96, 1'b0, 1'b0);
        rd(0, 4'h8, d); chk("R8 framing status", d, 32'h41);
        chk("R8 err pulse", c_err - base_err, 1);
        chk("R8 rx pulse", c_rx - base_rx, 1);
        rd(0, 4'h0, d); chk("R8 data", d, 32'h96);
        rd(0, 4'h8, d); chk("R4 framing cleared", d, 32'h0);

        // R9: parity error
        base_err = c_err;
        send_frame(8'h5B, 1'b1, 1'b1);
        rd(0, 4'h8, d); chk("R9 parity status", d, 32'h81);
        chk("R9 err pulse", c_err - base_err, 1);
        rd(0, 4'h0, d); chk("R9 data", d, 32'h5B);
        rd(0, 4'h8, d); chk("R4 parity cleared", d, 32'h0);

        // R10: divisor window, upper bits dropped, slower bit time
        wr(1, 4'h0, 32'hFFFF_0001);
        rd(1, 4'h0, d); chk("R10 divisor readback", d, 32'h1);
        div_cur = 1;
        send_frame(8'hA5, 1'b0, 1'b1);
        rd(0, 4'h8, d); chk("R10 rx at div 1 status", d, 32'h1);
        rd(0, 4'h0, d); chk("R10 rx at div 1 data", d, 32'hA5);
        wr(0, 4'h4, 32'h5A);
        repeat (15) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            if (i > 0) repeat (32) @(negedge clk);
            chk("R10 tx bit at div 1", {31'b0, serial_out}, {31'b0, tx_bit(8'h5A, i)});
        end
        repeat (40) @(negedge clk);
        rd(0, 4'h8, d); chk("R10 tx done at div 1", d, 32'h0);
        wr(1, 4'h0, 32'h0);
        div_cur = 0;

        // R11: disabled instance saw all of the above
        send_frame(8'h77, 1'b0, 1'b1);
        bus_req = 1'b1; bus_we = 1'b0; bus_win = 1'b0; bus_addr = 4'h8;
        #1 chk("R11 disabled status", off_rdata, 32'h0);
        chk("R2 enabled status same frame", rdata, 32'h1);
        @(negedge clk);
        bus_req = 1'b0;
        rd(0, 4'h0, d);
        chk("R11 disabled pulses", c_off, 0);
        chk("R11 disabled line high", c_off_low, 0);
        chk("R2 pulses one cycle", c_long, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule